// File: doc/BRIEF.md
# Slow Clock Error Detector

This block watches a peripheral clock from the bus clock domain and reports when that peripheral clock has become too slow. The peripheral clock is taken before any internal divider, brought into the bus domain through a two-flop synchronizer, and its rising edges are detected there. A counter measures bus-clock cycles since the most recent detected edge. If the gap grows past a window of 64 bus cycles, the block raises a live error level. In the same cycle it emits a single-cycle pulse that a register stage elsewhere can use to set a sticky interrupt flag.

The 64-cycle window is two periods at the threshold ratio of one thirty-second of the bus clock. The extra period covers synchronizer latency and sampling jitter. A peripheral clock faster than the threshold never produces an error, and a stalled or much slower clock always produces one. The error level clears once the clock has recovered. Detection is switched off by a disable control, and that control is only accepted while the generator that owns the clock is turned off. Turning the generator off, or running with detection disabled, holds the error low.

Top module: `slow_clk_monitor`

## Requirements
- R1: When more than 64 bus cycles pass between two consecutive synchronized rising edges of `mon_clk` (or after enabling, with no edge), `clk_err` goes to 1.
- R2: While rising edges of `mon_clk` arrive at most 64 bus cycles apart, `clk_err` stays 0 and no pulse occurs.
- R3: Boundary: a steady edge spacing of exactly 64 bus cycles gives no error, and a spacing of exactly 65 bus cycles gives an error.
- R4: Once raised, `clk_err` returns to 0 only after two consecutive edge-to-edge intervals that are each within the window. The first edge after a timeout only starts the first interval.
- R5: `chk_disable` = 1 turns detection off, so `clk_err` stays 0 and no pulse occurs. `chk_disable` = 0 turns detection on.
- R6: A new `chk_disable` value takes effect only while `gen_enable` is 0. A change made while `gen_enable` is 1 is not applied until the generator has been turned off.
- R7: `err_set_pulse` is high for exactly one bus cycle, in the same cycle that `clk_err` rises. It fires once per error episode, and both outputs are 0 after reset.
- R8: With `gen_enable` = 0, `clk_err` is 0 from the cycle after the disable, and no pulse occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mon_clk | input | 1 | Monitored peripheral clock, taken before any divider |
| chk_disable | input | 1 | 1 = detection off, 0 = detection on; accepted only while the generator is off |
| gen_enable | input | 1 | Generator enable |
| clk_err | output | 1 | Live clock-error level |
| err_set_pulse | output | 1 | One-cycle pulse that sets the sticky interrupt flag |

## Verification
Several properties are checked on every cycle. The pulse and the rising error level must coincide, and the pulse must never last two cycles. Disabling the generator must clear the error on the next cycle. A rising error must always be preceded by at least 64 cycles without a synchronized edge, measured by an independent gap counter in the checker. Other behaviours need whole stimulus histories, so only the bench scenarios can show them. These include the exact 64-versus-65 boundary, recovery after two good intervals, a single pulse per episode, and a disable request made while the generator is running being held back until the generator turns off.

// File: rtl/slow_clk_monitor.sv
module slow_clk_monitor #(
  parameter int RATIO = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mon_clk,
  input  logic chk_disable,
  input  logic gen_enable,
  output logic clk_err,
  output logic err_set_pulse
);
  localparam int LIMIT = 2 * RATIO;
  localparam int CW    = $clog2(LIMIT + 1);

  logic [2:0]    sync_q;
  logic          det_off_q;
  logic [CW-1:0] gap_q;
  logic [1:0]    good_q;

  logic mon_edge, active, in_window, timeout;

  assign mon_edge  = sync_q[1] & ~sync_q[2];
  assign active    = gen_enable & ~det_off_q;
  assign in_window = (gap_q != CW'(LIMIT));
  assign timeout   = ~mon_edge & (gap_q == CW'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], mon_clk};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)           det_off_q <= 1'b0;
    else if (!gen_enable) det_off_q <= chk_disable;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q         <= '0;
      good_q        <= '0;
      clk_err       <= 1'b0;
      err_set_pulse <= 1'b0;
    end else if (!active) begin
      gap_q         <= '0;
      good_q        <= '0;
      clk_err       <= 1'b0;
      err_set_pulse <= 1'b0;
    end else begin
      err_set_pulse <= 1'b0;
      if (mon_edge) begin
        gap_q <= '0;
        if (clk_err) begin
          if (!in_window)
            good_q <= '0;
          else if (good_q == 2'd1) begin
            good_q  <= '0;
            clk_err <= 1'b0;
          end else
            good_q <= good_q + 2'd1;
        end
      end else begin
        if (in_window) gap_q <= gap_q + CW'(1);
        if (timeout) begin
          good_q <= '0;
          if (!clk_err) begin
            clk_err       <= 1'b1;
            err_set_pulse <= 1'b1;
          end
        end
      end
    end
  end
endmodule

module slow_clk_monitor_chk #(
  parameter int LIMIT = 64
) (
  input logic clk,
  input logic rst_n,
  input logic gen_enable,
  input logic mon_edge,
  input logic clk_err,
  input logic err_set_pulse
);
  localparam int GW = $clog2(LIMIT + 1);
  logic [GW-1:0] gap;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                  gap <= '0;
    else if (mon_edge)           gap <= '0;
    else if (gap != GW'(LIMIT))  gap <= gap + GW'(1);

  assert_pulse_with_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_set_pulse |-> $rose(clk_err));
  assert_rise_with_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_err) |-> err_set_pulse);
  assert_pulse_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_set_pulse |=> !err_set_pulse);
  assert_gen_off_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_enable |=> !clk_err);
  assert_rise_needs_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_err) |-> (gap == GW'(LIMIT)));
endmodule

bind slow_clk_monitor slow_clk_monitor_chk #(.LIMIT(2 * RATIO)) u_chk (
  .clk(clk), .rst_n(rst_n), .gen_enable(gen_enable), .mon_edge(mon_edge),
  .clk_err(clk_err), .err_set_pulse(err_set_pulse)
);

// File: tb/slow_clk_monitor_test.sv
module slow_clk_monitor_test;
  logic clk = 1'b0, rst_n = 1'b0, mon_clk = 1'b0;
  logic chk_disable = 1'b0, gen_enable = 1'b1;
  logic clk_err, err_set_pulse;
  int compared = 0, mismatched = 0, pulses = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  slow_clk_monitor uut (
    .clk(clk), .rst_n(rst_n), .mon_clk(mon_clk), .chk_disable(chk_disable),
    .gen_enable(gen_enable), .clk_err(clk_err), .err_set_pulse(err_set_pulse)
  );

  always @(negedge clk) if (rst_n && err_set_pulse) pulses++;

  function automatic logic expect_err(int p);
    return p > 64;
  endfunction

  task automatic check(string req, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run(int p, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      mon_clk = ((i % p) < (p / 2));
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      mon_clk = 1'b0;
    end
  endtask

  task automatic report;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #(5ns * 150000);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

  initial begin
    int base, p;
    void'($urandom(32'd20240611));
    idle(5);
    rst_n = 1'b1;
    idle(1);
    check("R7 reset err", clk_err, 0);
    check("R7 reset pulse", err_set_pulse, 0);

    run(10, 400);
    check("R2 fast clock err", clk_err, 0);
    check("R2 fast clock pulses", pulses, 0);

    run(64, 400);
    check("R3 spacing 64 err", clk_err, 0);
    check("R3 spacing 64 pulses", pulses, 0);

    run(65, 400);
    check("R3 spacing 65 err", clk_err, 1);
    check("R7 one pulse per episode", pulses, 1);

    idle(200);
    check("R1 stalled clock err", clk_err, 1);
    check("R7 no repeat pulse", pulses, 1);

    run(20, 35);
    check("R4 two edges not enough", clk_err, 1);
    run(20, 20);
    check("R4 recovered", clk_err, 0);

    idle(100);
    check("R1 stall again err", clk_err, 1);
    check("R1 second episode pulse", pulses, 2);

    gen_enable = 1'b0;
    idle(2);
    check("R8 gen off clears", clk_err, 0);
    idle(200);
    check("R8 gen off stalled err", clk_err, 0);
    check("R8 gen off pulses", pulses, 2);

    chk_disable = 1'b1;
    idle(2);
    gen_enable = 1'b1;
    idle(200);
    check("R5 detection off err", clk_err, 0);
    check("R5 detection off pulses", pulses, 2);

    chk_disable = 1'b0;
    idle(200);
    check("R6 change while running ignored", clk_err, 0);
    gen_enable = 1'b0;
    idle(2);
    gen_enable = 1'b1;
    idle(100);
    check("R6 change applied after gen off", clk_err, 1);
    check("R5 detection on pulses", pulses, 3);

    for (int k = 0; k < 20; k++) begin
      p = 8 + int'($urandom_range(112));
      gen_enable = 1'b0;
      idle(3);
      gen_enable = 1'b1;
      base = pulses;
      run(p, 4 * p + 150);
      check(expect_err(p) ? "R1 random slow err" : "R2 random fast err",
            clk_err, int'(expect_err(p)));
      check(expect_err(p) ? "R1 random slow pulses" : "R2 random fast pulses",
            pulses - base, int'(expect_err(p)));
    end

    done = 1'b1;
    report();
  end
endmodule